// File: doc/BRIEF.md
# Multi-Source Trigger Combiner

This block merges many hit and trigger sources into one detector trigger. Each source has its own bit in a 32-bit enable word. The sources are:

- a software burst;
- an internal periodic pulser;
- three grand ORs: external NIM/eSATA lines, 16-channel ADC links and 32-channel ADC links;
- four multiplicity thresholds over the sixteen 16-channel links;
- a top/bottom link coincidence;
- four mask-programmed coincidence terms.

A rising edge of the OR of all enabled sources is an offered trigger. It is accepted only when no trigger window and no busy window is running. An accepted trigger produces an output pulse stretched to a programmed width. It can also open a busy lockout of programmed length.

Three 32-bit counters track offered triggers, accepted triggers and pulser pulses. They start at zero after a synchronous reset and wrap modulo 2^32. The pulser runs from a width/period pair and can be driven to its own output pin.

Top module: `trig_combine`

## Requirements
- R1: Only enable bits 0, 1, 5–12 and 16–19 select trigger sources; with all of those clear and only bits 2, 13 and 15 set, no input activity changes `trigOut` or `cntIn`.
- R2: An offer is a rising edge of the OR of enabled sources; each offer adds exactly one to `cntIn`, and a level held high for many cycles counts once.
- R3: An offer seen while `trigOut` and `busyOut` are both low is accepted: `trigOut` goes high in the next cycle for `trigWidthCfg` cycles (a value of 0 acts as 1) and `cntAcc` adds one; an offer during a running trigger window is counted in `cntIn` only.
- R4: When enable bit 14 is set, an accepted trigger also raises `busyOut` from the next cycle for `busyWidthCfg` cycles; an offer during that window adds to `cntIn` but not `cntAcc`; with bit 14 clear `busyOut` stays low.
- R5: Enable bits 8, 9, 10, 11 select "at least 1, 2, 3, 4 of the sixteen `linkHits` bits set".
- R6: Enable bit 16+k selects coincidence term k (k = 0..3), with mask `coincMask[16*k +: 16]`; it fires when the mask is non-zero and every masked link bit is set.
- R7: Enable bit 12 selects the link coincidence: any of `linkHits[7:0]` and any of `linkHits[15:8]` set together.
- R8: Enable bits 5, 6, 7 select the OR of `extHits`, of `linkHits` and of `adc32Hits`.
- R9: With bit 3 set the pulser repeats every `pulsePeriodCfg` cycles, high for `pulseWidthCfg` cycles of each period; each pulse adds one to `cntPulse`. Bit 1 offers it as a trigger, and bit 4 drives it onto `pulserOut` (otherwise low).
- R10: A one-cycle `swTrigWrite` strobe arms a train of 10 one-cycle pulses separated by idle cycles; with bit 0 set each pulse is a separate offer.
- R11: During and right after reset `trigOut`, `busyOut`, `pulserOut` and all three counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcEnable | input | 32 | Source and mode enable word |
| trigWidthCfg | input | 32 | Trigger output width in cycles |
| busyWidthCfg | input | 32 | Busy lockout length in cycles |
| pulseWidthCfg | input | 32 | Pulser high time in cycles |
| pulsePeriodCfg | input | 32 | Pulser period in cycles |
| swTrigWrite | input | 1 | Strobe arming the software pulse train |
| linkHits | input | 16 | Hit bits of the 16-channel ADC links |
| adc32Hits | input | 16 | Hit bits of the 32-channel ADC links |
| extHits | input | 32 | External NIM/eSATA hit bits |
| coincMask | input | 64 | Four 16-bit coincidence masks, term k at bits 16k+15..16k |
| trigOut | output | 1 | Stretched trigger pulse |
| busyOut | output | 1 | Busy lockout flag |
| pulserOut | output | 1 | Pulser level when routed out |
| cntIn | output | 32 | Offered trigger count |
| cntAcc | output | 32 | Accepted trigger count |
| cntPulse | output | 32 | Pulser pulse count |

## Verification
The hardest case is an offer that arrives while a lockout is already running. It needs a falling edge and then a new rising edge of the combined source inside the window. The stimulus drops the link hits and raises them again a few cycles after the first acceptance, so that the second edge falls inside a 20-cycle busy window or a 10-cycle trigger window. It then compares how far the offered and accepted counters each moved. The pulser as a trigger source is checked by requiring that the offered count and the pulse count move by the same non-zero amount.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CNT_W = 32;
  localparam int EN_W  = 32;

  // enable word bit positions
  localparam int EN_SW        = 0;
  localparam int EN_PULSER    = 1;
  localparam int EN_RUN_PULSE = 3;
  localparam int EN_PULSE_OUT = 4;
  localparam int EN_EXT_OR    = 5;
  localparam int EN_L16_OR    = 6;
  localparam int EN_L32_OR    = 7;
  localparam int EN_MULT_BASE = 8;
  localparam int EN_L16_COINC = 12;
  localparam int EN_BUSY      = 14;
  localparam int EN_COINC_BASE = 16;

  typedef struct packed {
    logic countOffer;
    logic countAccept;
  } ctrlStrobe_t;
endpackage

// File: rtl/trig_dpath.sv
module trig_dpath
  import trig_pkg::*;
#(
  parameter int N_LINK16 = 16,
  parameter int N_LINK32 = 16,
  parameter int N_EXT    = 32,
  parameter int N_MULT   = 4,
  parameter int N_COINC  = 4,
  parameter int SW_BURST = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [EN_W-1:0]           srcEnable,
  input  logic [CNT_W-1:0]          pulseWidthCfg,
  input  logic [CNT_W-1:0]          pulsePeriodCfg,
  input  logic                      swTrigWrite,
  input  logic [N_LINK16-1:0]       linkHits,
  input  logic [N_LINK32-1:0]       adc32Hits,
  input  logic [N_EXT-1:0]          extHits,
  input  logic [N_COINC*N_LINK16-1:0] coincMask,
  input  ctrlStrobe_t               strobe,
  output logic                      offered,
  output logic                      pulserOut,
  output logic [CNT_W-1:0]          cntIn,
  output logic [CNT_W-1:0]          cntAcc,
  output logic [CNT_W-1:0]          cntPulse
);
  localparam int HIT_W  = $clog2(N_LINK16 + 1);
  localparam int SW_W   = $clog2(2 * SW_BURST + 1);
  localparam int HALF16 = N_LINK16 / 2;

  // link multiplicity
  logic [HIT_W-1:0] hitCount;
  always_comb begin
    hitCount = '0;
    for (int i = 0; i < N_LINK16; i++) begin
      hitCount = hitCount + HIT_W'(linkHits[i]);
    end
  end

  logic [N_MULT-1:0] multTerm;
  genvar k;
  generate
    for (k = 0; k < N_MULT; k++) begin : g_mult
      assign multTerm[k] = 32'(hitCount) >= 32'(k + 1);
    end
  endgenerate

  // mask coincidence terms
  logic [N_COINC-1:0] coincTerm;
  generate
    for (k = 0; k < N_COINC; k++) begin : g_coinc
      logic [N_LINK16-1:0] termMask;
      assign termMask     = coincMask[k*N_LINK16 +: N_LINK16];
      assign coincTerm[k] = (|termMask) && ((linkHits & termMask) == termMask);
    end
  endgenerate

  logic topBottomCoinc;
  assign topBottomCoinc = (|linkHits[HALF16-1:0]) && (|linkHits[N_LINK16-1:HALF16]);

  // software pulse train: odd remaining counts are high
  logic [SW_W-1:0] swRemain;
  logic            swLevel;
  always_ff @(posedge clk) begin
    if (rst) begin
      swRemain <= '0;
    end else if (swTrigWrite) begin
      swRemain <= SW_W'(2 * SW_BURST);
    end else if (swRemain != '0) begin
      swRemain <= swRemain - SW_W'(1);
    end
  end
  assign swLevel = swRemain[0];

  // periodic pulser
  logic             runActive;
  logic [CNT_W-1:0] phase;
  logic             wrapNow;
  logic             pulserLevel;
  logic             pulseStart;

  assign wrapNow = (pulsePeriodCfg <= CNT_W'(1)) ||
                   (phase >= pulsePeriodCfg - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !srcEnable[EN_RUN_PULSE]) begin
      runActive <= 1'b0;
      phase     <= '0;
    end else begin
      runActive <= 1'b1;
      if (!runActive || wrapNow) phase <= '0;
      else                       phase <= phase + CNT_W'(1);
    end
  end

  assign pulserLevel = runActive && (phase < pulseWidthCfg);
  assign pulseStart  = runActive && (phase == '0) && (pulseWidthCfg != '0);
  assign pulserOut   = pulserLevel && srcEnable[EN_PULSE_OUT];

  // source vector aligned to the enable word
  logic [EN_W-1:0] srcVec;
  always_comb begin
    srcVec               = '0;
    srcVec[EN_SW]        = swLevel;
    srcVec[EN_PULSER]    = pulserLevel;
    srcVec[EN_EXT_OR]    = |extHits;
    srcVec[EN_L16_OR]    = |linkHits;
    srcVec[EN_L32_OR]    = |adc32Hits;
    srcVec[EN_L16_COINC] = topBottomCoinc;
    for (int m = 0; m < N_MULT; m++)  srcVec[EN_MULT_BASE + m]  = multTerm[m];
    for (int c = 0; c < N_COINC; c++) srcVec[EN_COINC_BASE + c] = coincTerm[c];
  end
  assign offered = |(srcVec & srcEnable);

  // counters, wrap modulo 2^CNT_W
  always_ff @(posedge clk) begin
    if (rst) begin
      cntIn    <= '0;
      cntAcc   <= '0;
      cntPulse <= '0;
    end else begin
      if (strobe.countOffer)  cntIn    <= cntIn + CNT_W'(1);
      if (strobe.countAccept) cntAcc   <= cntAcc + CNT_W'(1);
      if (pulseStart)         cntPulse <= cntPulse + CNT_W'(1);
    end
  end
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             offered,
  input  logic             busyEnable,
  input  logic [CNT_W-1:0] trigWidthCfg,
  input  logic [CNT_W-1:0] busyWidthCfg,
  output ctrlStrobe_t      strobe,
  output logic             trigOut,
  output logic             busyOut
);
  logic             offeredQ;
  logic             offerEdge;
  logic             accept;
  logic [CNT_W-1:0] trigRemain;
  logic [CNT_W-1:0] busyRemain;
  logic [CNT_W-1:0] trigLoad;

  assign offerEdge = offered && !offeredQ;
  assign accept    = offerEdge && (trigRemain == '0) && (busyRemain == '0);
  assign trigLoad  = (trigWidthCfg == '0) ? CNT_W'(1) : trigWidthCfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      offeredQ   <= 1'b0;
      trigRemain <= '0;
      busyRemain <= '0;
    end else begin
      offeredQ <= offered;
      if (accept)                trigRemain <= trigLoad;
      else if (trigRemain != '0) trigRemain <= trigRemain - CNT_W'(1);
      if (accept && busyEnable)  busyRemain <= busyWidthCfg;
      else if (busyRemain != '0) busyRemain <= busyRemain - CNT_W'(1);
    end
  end

  always_comb begin
    strobe.countOffer  = offerEdge;
    strobe.countAccept = accept;
  end

  assign trigOut = trigRemain != '0;
  assign busyOut = busyRemain != '0;
endmodule

// File: rtl/trig_combine.sv
module trig_combine
  import trig_pkg::*;
#(
  parameter int N_LINK16 = 16,
  parameter int N_LINK32 = 16,
  parameter int N_EXT    = 32,
  parameter int N_MULT   = 4,
  parameter int N_COINC  = 4,
  parameter int SW_BURST = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [31:0]                 srcEnable,
  input  logic [31:0]                 trigWidthCfg,
  input  logic [31:0]                 busyWidthCfg,
  input  logic [31:0]                 pulseWidthCfg,
  input  logic [31:0]                 pulsePeriodCfg,
  input  logic                        swTrigWrite,
  input  logic [N_LINK16-1:0]         linkHits,
  input  logic [N_LINK32-1:0]         adc32Hits,
  input  logic [N_EXT-1:0]            extHits,
  input  logic [N_COINC*N_LINK16-1:0] coincMask,
  output logic                        trigOut,
  output logic                        busyOut,
  output logic                        pulserOut,
  output logic [31:0]                 cntIn,
  output logic [31:0]                 cntAcc,
  output logic [31:0]                 cntPulse
);
  ctrlStrobe_t strobe;
  logic        offered;

  trig_dpath #(
    .N_LINK16(N_LINK16), .N_LINK32(N_LINK32), .N_EXT(N_EXT),
    .N_MULT(N_MULT), .N_COINC(N_COINC), .SW_BURST(SW_BURST)
  ) u_dpath (
    .clk(clk), .rst(rst), .srcEnable(srcEnable),
    .pulseWidthCfg(pulseWidthCfg), .pulsePeriodCfg(pulsePeriodCfg),
    .swTrigWrite(swTrigWrite), .linkHits(linkHits), .adc32Hits(adc32Hits),
    .extHits(extHits), .coincMask(coincMask), .strobe(strobe),
    .offered(offered), .pulserOut(pulserOut),
    .cntIn(cntIn), .cntAcc(cntAcc), .cntPulse(cntPulse)
  );

  trig_ctrl u_ctrl (
    .clk(clk), .rst(rst), .offered(offered),
    .busyEnable(srcEnable[EN_BUSY]),
    .trigWidthCfg(trigWidthCfg), .busyWidthCfg(busyWidthCfg),
    .strobe(strobe), .trigOut(trigOut), .busyOut(busyOut)
  );
endmodule

// File: rtl/trig_combine_chk.sv
module trig_combine_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] srcEnable,
  input logic        trigOut,
  input logic        busyOut,
  input logic        pulserOut,
  input logic [31:0] cntIn,
  input logic [31:0] cntAcc,
  input logic [31:0] cntPulse
);
  // R3
  acc_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trigOut) |-> (cntAcc == $past(cntAcc) + 32'd1));

  // R3
  rise_on_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (cntAcc != $past(cntAcc)) |-> $rose(trigOut));

  // R2
  in_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cntIn == $past(cntIn)) || (cntIn == $past(cntIn) + 32'd1));

  // R2
  acc_implies_in_chk: assert property (@(posedge clk) disable iff (rst)
    (cntAcc != $past(cntAcc)) |-> (cntIn != $past(cntIn)));

  // R4
  busy_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busyOut) |-> ($past(srcEnable[14]) && $rose(trigOut)));

  // R4
  no_trig_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trigOut) |-> !$past(busyOut));

  // R9
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    (cntPulse != $past(cntPulse)) |-> $past(srcEnable[3], 2));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cntIn == 32'd0 && cntAcc == 32'd0 && cntPulse == 32'd0 &&
             !trigOut && !busyOut && !pulserOut));
endmodule

bind trig_combine trig_combine_chk u_chk (
  .clk(clk), .rst(rst), .srcEnable(srcEnable), .trigOut(trigOut),
  .busyOut(busyOut), .pulserOut(pulserOut), .cntIn(cntIn),
  .cntAcc(cntAcc), .cntPulse(cntPulse)
);

// File: tb/sim_trig_combine.sv
`timescale 1ns/1ps
module sim_trig_combine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcEnable = '0;
  logic [31:0] trigWidthCfg = 32'd3;
  logic [31:0] busyWidthCfg = '0;
  logic [31:0] pulseWidthCfg = 32'd3;
  logic [31:0] pulsePeriodCfg = 32'd8;
  logic        swTrigWrite = 1'b0;
  logic [15:0] linkHits = '0;
  logic [15:0] adc32Hits = '0;
  logic [31:0] extHits = '0;
  logic [63:0] coincMask = '0;
  logic        trigOut, busyOut, pulserOut;
  logic [31:0] cntIn, cntAcc, cntPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  trig_combine u0 (
    .clk(clk), .rst(rst), .srcEnable(srcEnable), .trigWidthCfg(trigWidthCfg),
    .busyWidthCfg(busyWidthCfg), .pulseWidthCfg(pulseWidthCfg),
    .pulsePeriodCfg(pulsePeriodCfg), .swTrigWrite(swTrigWrite),
    .linkHits(linkHits), .adc32Hits(adc32Hits), .extHits(extHits),
    .coincMask(coincMask), .trigOut(trigOut), .busyOut(busyOut),
    .pulserOut(pulserOut), .cntIn(cntIn), .cntAcc(cntAcc), .cntPulse(cntPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one-cycle stimulus, then settle and compare counter deltas
  task automatic offer(input logic [15:0] l, input logic [15:0] a, input logic [31:0] e,
                       input int expIn, input int expAcc, input string tag);
    logic [31:0] in0, acc0;
    @(negedge clk);
    in0 = cntIn; acc0 = cntAcc;
    linkHits = l; adc32Hits = a; extHits = e;
    @(negedge clk);
    linkHits = '0; adc32Hits = '0; extHits = '0;
    repeat (30) @(negedge clk);
    check({tag, " in"}, cntIn - in0, expIn);
    check({tag, " acc"}, cntAcc - acc0, expAcc);
  endtask

  task automatic t_reset();
    // R11
    repeat (3) @(negedge clk);
    check("R11 trigOut", {31'd0, trigOut}, 0);
    check("R11 busyOut", {31'd0, busyOut}, 0);
    check("R11 cntIn", cntIn, 0);
    check("R11 cntAcc", cntAcc, 0);
    check("R11 cntPulse", cntPulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 pulserOut", {31'd0, pulserOut}, 0);
  endtask

  task automatic t_gating();
    // R1: only ignored bits set
    srcEnable = (32'd1 << 2) | (32'd1 << 13) | (32'd1 << 15);
    coincMask = '1;
    offer(16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 0, 0, "R1 ignored bits");
    coincMask = '0;
    // R8: grand ORs
    srcEnable = 32'd1 << 5;
    offer(16'h0, 16'h0, 32'h0010_0000, 1, 1, "R8 ext or");
    offer(16'h0001, 16'h0001, 32'h0, 0, 0, "R8 ext only");
    srcEnable = 32'd1 << 6;
    offer(16'h8000, 16'h0, 32'h0, 1, 1, "R8 link16 or");
    srcEnable = 32'd1 << 7;
    offer(16'h0, 16'h0200, 32'h0, 1, 1, "R8 link32 or");
  endtask

  task automatic t_mult();
    // R5
    srcEnable = 32'd1 << 8;
    offer(16'h0400, 16'h0, 32'h0, 1, 1, "R5 >=1");
    srcEnable = 32'd1 << 9;
    offer(16'h0001, 16'h0, 32'h0, 0, 0, "R5 >=2 with 1");
    srcEnable = 32'd1 << 10;
    offer(16'h0101, 16'h0, 32'h0, 0, 0, "R5 >=3 with 2");
    offer(16'h1101, 16'h0, 32'h0, 1, 1, "R5 >=3 with 3");
    srcEnable = 32'd1 << 11;
    offer(16'h1101, 16'h0, 32'h0, 0, 0, "R5 >=4 with 3");
    offer(16'hF000, 16'h0, 32'h0, 1, 1, "R5 >=4 with 4");
  endtask

  task automatic t_coinc();
    // R6
    coincMask = 64'h0000_0000_0030_0000;
    srcEnable = 32'd1 << 17;
    offer(16'h0010, 16'h0, 32'h0, 0, 0, "R6 partial");
    offer(16'h0030, 16'h0, 32'h0, 1, 1, "R6 full");
    srcEnable = 32'd1 << 16;
    offer(16'hFFFF, 16'h0, 32'h0, 0, 0, "R6 empty mask");
    coincMask = 64'h8001_0000_0000_0000;
    srcEnable = 32'd1 << 19;
    offer(16'h8001, 16'h0, 32'h0, 1, 1, "R6 term3");
    coincMask = '0;
    // R7
    srcEnable = 32'd1 << 12;
    offer(16'h00FF, 16'h0, 32'h0, 0, 0, "R7 low half");
    offer(16'h0101, 16'h0, 32'h0, 1, 1, "R7 both halves");
  endtask

  task automatic t_stretch();
    int highs;
    logic [31:0] in0, acc0;
    // R3: width 5
    srcEnable = 32'd1 << 6;
    trigWidthCfg = 32'd5;
    @(negedge clk);
    linkHits = 16'h0001;
    @(negedge clk);
    check("R3 trig next cycle", {31'd0, trigOut}, 1);
    linkHits = '0;
    highs = 1;
    repeat (20) begin @(negedge clk); if (trigOut) highs++; end
    check("R3 width 5", highs, 5);
    // R3: width 0 acts as 1
    trigWidthCfg = 32'd0;
    highs = 0;
    @(negedge clk);
    linkHits = 16'h0001;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) linkHits = '0;
      if (trigOut) highs++;
    end
    check("R3 width 0", highs, 1);
    // R2: held level counts once
    trigWidthCfg = 32'd2;
    @(negedge clk);
    in0 = cntIn; acc0 = cntAcc;
    linkHits = 16'h0001;
    repeat (30) @(negedge clk);
    linkHits = '0;
    repeat (5) @(negedge clk);
    check("R2 held in", cntIn - in0, 1);
    check("R2 held acc", cntAcc - acc0, 1);
    // R3: offer during trigger window
    trigWidthCfg = 32'd10;
    @(negedge clk);
    in0 = cntIn; acc0 = cntAcc;
    linkHits = 16'h0001;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 1) linkHits = '0;
      if (i == 3) linkHits = 16'h0001;
      if (i == 5) linkHits = '0;
    end
    check("R3 window in", cntIn - in0, 2);
    check("R3 window acc", cntAcc - acc0, 1);
    trigWidthCfg = 32'd3;
  endtask

  task automatic t_busy();
    int highs;
    logic [31:0] in0, acc0;
    // R4
    srcEnable = (32'd1 << 6) | (32'd1 << 14);
    trigWidthCfg = 32'd2;
    busyWidthCfg = 32'd20;
    @(negedge clk);
    in0 = cntIn; acc0 = cntAcc;
    linkHits = 16'h0001;
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busyOut) highs++;
      if (i == 1) linkHits = '0;
      if (i == 3) linkHits = 16'h0001;
      if (i == 5) linkHits = '0;
    end
    check("R4 busy length", highs, 20);
    check("R4 busy in", cntIn - in0, 2);
    check("R4 busy acc", cntAcc - acc0, 1);
    // R4: busy disabled
    srcEnable = 32'd1 << 6;
    @(negedge clk);
    linkHits = 16'h0001;
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 0) linkHits = '0;
      if (busyOut) highs++;
    end
    check("R4 busy off", highs, 0);
    busyWidthCfg = '0;
  endtask

  task automatic t_pulser();
    int highs;
    logic [31:0] p0, in0, acc0;
    // R9: period 8, width 3, routed out
    trigWidthCfg = 32'd1;
    pulseWidthCfg = 32'd3;
    pulsePeriodCfg = 32'd8;
    @(negedge clk);
    p0 = cntPulse; in0 = cntIn;
    srcEnable = (32'd1 << 3) | (32'd1 << 4);
    highs = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pulserOut) highs++;
    end
    check("R9 pulser highs", highs, 12);
    check("R9 pulse count", cntPulse - p0, 4);
    check("R9 not a trigger without bit1", cntIn - in0, 0);
    // R9: not routed out without bit 4
    srcEnable = 32'd1 << 3;
    highs = 0;
    repeat (16) begin @(negedge clk); if (pulserOut) highs++; end
    check("R9 output gated", highs, 0);
    srcEnable = '0;
    repeat (4) @(negedge clk);
    // R9: pulser as trigger source
    p0 = cntPulse; in0 = cntIn; acc0 = cntAcc;
    srcEnable = (32'd1 << 1) | (32'd1 << 3);
    repeat (40) @(negedge clk);
    srcEnable = 32'd1 << 1;
    repeat (10) @(negedge clk);
    check("R9 trigger offers match pulses", cntIn - in0, cntPulse - p0);
    check("R9 trigger accepts match pulses", cntAcc - acc0, cntPulse - p0);
    check("R9 pulses nonzero", {31'd0, (cntPulse != p0)}, 1);
    srcEnable = '0;
  endtask

  task automatic t_sw();
    logic [31:0] in0, acc0;
    // R10
    trigWidthCfg = 32'd1;
    srcEnable = 32'd1;
    @(negedge clk);
    in0 = cntIn; acc0 = cntAcc;
    swTrigWrite = 1'b1;
    @(negedge clk);
    swTrigWrite = 1'b0;
    repeat (40) @(negedge clk);
    check("R10 burst in", cntIn - in0, 10);
    check("R10 burst acc", cntAcc - acc0, 10);
    srcEnable = '0;
    in0 = cntIn;
    swTrigWrite = 1'b1;
    @(negedge clk);
    swTrigWrite = 1'b0;
    repeat (40) @(negedge clk);
    check("R10 disabled", cntIn - in0, 0);
  endtask

  initial begin
    t_reset();
    t_gating();
    t_mult();
    t_coinc();
    t_stretch();
    t_busy();
    t_pulser();
    t_sw();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule